// File: doc/BRIEF.md
# Serial ADC Power-Up and Auto-Mode Sequencer

This block is a host-side controller for a serial analog-to-digital converter. The converter is reached over a four-wire link: an active-low chip select, a serial clock, a command line toward the converter and a data line back from it. Every transfer is a frame of sixteen serial clocks with chip select held low. After reset the controller runs a fixed three-frame start-up. The first two frames hold the command line high on every clock. The third frame writes a control word that places the converter in the configured power mode. From then on the converter keeps that mode.

A conversion starts with a one-cycle `start` pulse. In either auto low-power mode the converter sleeps after each frame. The controller therefore sends a wake frame first, with the command line held low, and then the real conversion frame. Only the result of the real frame is reported. In the other modes a single frame is enough. A new power mode and channel can be loaded at any time. The load is held and goes out as a control-word write at the start of the next conversion frame that is not a wake frame.

The serial clock comes from the system clock divided by a parameter. Wake-up time is not measured. It is covered by the length of one full wake frame.

Top module: `adc_pwr_seq_ctrl`

## Requirements
- R1: While reset is held, chip select and serial clock are high, `res_valid` is low and `busy` is high (start-up is pending).
- R2: Each frame has exactly 16 rising serial clock edges while chip select is low, and the serial clock is high whenever chip select is high.
- R3: After reset the first two frames carry all ones on the command line (16'hFFFF). The third frame carries the control word with write bit 1 and the pending configuration. `busy` falls only after the third frame, and no result is reported during start-up.
- R4: The 16-bit command word is sent MSB first and changes only while the serial clock is low. A control write is {1'b1, 1'b0, chan[3:0], pm[1:0], 4'b0001, 4'b0000}. The converter reads the top 12 bits.
- R5: A start while the active power mode is auto (pm[1] = 0, where 00 is auto standby and 01 is auto shutdown) produces two frames. The first is a wake frame with an all-zero command word, so the write bit is 0. Only the second frame's data is reported.
- R6: A start while the active power mode is 11 (normal) or 10 (full shutdown) produces one frame.
- R7: `res_valid` pulses for exactly one system clock, one clock after the chip-select rising edge that ends a conversion frame. `res_chan` holds the first 4 bits received and `res_data` holds the last 12, in the order received, most significant first.
- R8: `cfg_load` stores `cfg_pm`/`cfg_chan` as pending. The next conversion frame (never a wake frame, never the frame already in progress) sends them as a control write. A conversion frame with nothing pending sends an all-zero command word.
- R9: A `start` while `busy` is high is ignored. No extra frame is sent and no extra result is reported.
- R10: Whether a wake frame is inserted depends on the power mode already written to the converter when `start` is accepted, not on a pending load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Store cfg_pm/cfg_chan as pending configuration |
| cfg_pm | input | 2 | Power mode bits (00 auto standby, 01 auto shutdown, 10 full shutdown, 11 normal) |
| cfg_chan | input | 4 | Channel address for the control word |
| start | input | 1 | One-cycle request for a conversion |
| busy | output | 1 | Start-up or conversion in progress |
| res_valid | output | 1 | One-cycle strobe for a valid result |
| res_chan | output | 4 | Channel identifier of the result |
| res_data | output | 12 | Conversion result |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock, idles high |
| adc_din | output | 1 | Command bit toward the converter |
| adc_dout | input | 1 | Data bit from the converter |

## Verification
The bench models the converter. For every frame it returns a distinct data word and records the command word and the clock count of that frame. Conversions run in auto standby, auto shutdown, normal and full shutdown. Comparing frame counts and the reported word separates wake-inserting modes from single-frame modes and shows which frame's data is reported. Loads made while idle are checked against loads made inside a frame, which shows whether a load leaks into the current frame or into a wake frame. A load that switches between auto and non-auto modes shows that the decision to insert a wake frame follows the mode already written. A second start given mid-conversion must leave both the frame count and the result count unchanged.

// File: rtl/adc_seq_pkg.sv
// Package: shared constants, configuration type and helpers for the
// serial converter sequencer. Assumes a 16-clock frame with a 12-bit
// control field at its head.
package adc_seq_pkg;

    localparam int FRAME_W = 16;
    localparam int CTRL_W  = 12;
    localparam int CHAN_W  = 4;
    localparam int PM_W    = 2;
    localparam int DATA_W  = FRAME_W - CHAN_W;

    // Requested converter configuration.
    typedef struct packed {
        logic [PM_W-1:0]   pm;
        logic [CHAN_W-1:0] chan;
    } cfg_t;

    // Power modes whose top bit is clear sleep after every frame.
    function automatic logic pm_is_auto(input logic [PM_W-1:0] pm);
        return ~pm[PM_W-1];
    endfunction

endpackage

// File: rtl/adc_ctrl_word.sv
// Module: builds the 16-bit command word for a control-register write.
// Layout (MSB first): write, sequence-off, channel, power mode, fixed
// low option bits, then four zero padding bits that the converter ignores.
module adc_ctrl_word
    import adc_seq_pkg::*;
#(
    parameter logic [3:0] CTRL_LOW = 4'b0001
) (
    input  logic               wr,
    input  cfg_t               cfg,
    output logic [FRAME_W-1:0] word
);
    localparam int PAD_W = FRAME_W - CTRL_W;

    // Concatenate the control field and padding.
    always_comb begin
        word = {wr, 1'b0, cfg.chan, cfg.pm, CTRL_LOW, {PAD_W{1'b0}}};
    end

endmodule

// File: rtl/adc_frame_xfer.sv
// Module: one serial frame engine. On go (while ready) it lowers chip
// select, waits one half period, then clocks FRAME_W bits: command bit
// set when the serial clock falls, return bit sampled when it rises.
// After the last high phase chip select rises with frame_end, followed
// by a quiet gap. Assumes HALF >= 1 and QUIET >= 1.
module adc_frame_xfer #(
    parameter int HALF    = 2,
    parameter int QUIET   = 3,
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [FRAME_W-1:0] word,
    output logic               ready,
    output logic               frame_end,
    output logic [FRAME_W-1:0] rx_word,
    output logic               cs_n,
    output logic               sclk,
    output logic               din,
    input  logic               dout
);
    localparam int CNT_MAX = (HALF > QUIET) ? HALF : QUIET;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int BIT_W   = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] HALF_LAST  = CNT_W'(HALF - 1);
    localparam logic [CNT_W-1:0] QUIET_LAST = CNT_W'(QUIET - 1);
    localparam logic [BIT_W-1:0] BIT_LAST   = BIT_W'(FRAME_W - 1);

    typedef enum logic [2:0] {X_IDLE, X_LEAD, X_LOW, X_HIGH, X_QUIET} xst_e;

    xst_e               st;
    logic [CNT_W-1:0]   cnt;
    logic [BIT_W-1:0]   bit_idx;
    logic [FRAME_W-1:0] tx;

    assign ready = (st == X_IDLE);

    // Frame timing, shifting and link pin generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= X_IDLE;
            cnt       <= '0;
            bit_idx   <= '0;
            tx        <= '0;
            rx_word   <= '0;
            cs_n      <= 1'b1;
            sclk      <= 1'b1;
            din       <= 1'b0;
            frame_end <= 1'b0;
        end else begin
            frame_end <= 1'b0;
            case (st)
                X_IDLE: begin
                    if (go) begin
                        tx   <= word;
                        cs_n <= 1'b0;
                        cnt  <= '0;
                        st   <= X_LEAD;
                    end
                end
                X_LEAD: begin
                    if (cnt == HALF_LAST) begin
                        cnt     <= '0;
                        bit_idx <= '0;
                        sclk    <= 1'b0;
                        din     <= tx[FRAME_W-1];
                        st      <= X_LOW;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                X_LOW: begin
                    if (cnt == HALF_LAST) begin
                        cnt     <= '0;
                        sclk    <= 1'b1;
                        rx_word <= {rx_word[FRAME_W-2:0], dout};
                        st      <= X_HIGH;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                X_HIGH: begin
                    if (cnt == HALF_LAST) begin
                        cnt <= '0;
                        if (bit_idx == BIT_LAST) begin
                            cs_n      <= 1'b1;
                            din       <= 1'b0;
                            frame_end <= 1'b1;
                            st        <= X_QUIET;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            sclk    <= 1'b0;
                            din     <= tx[FRAME_W-2];
                            tx      <= {tx[FRAME_W-2:0], 1'b0};
                            st      <= X_LOW;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                X_QUIET: begin
                    if (cnt == QUIET_LAST) begin
                        cnt <= '0;
                        st  <= X_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= X_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/adc_seq_fsm.sv
// Module: frame-level sequencer. Runs the three-frame start-up, then for
// each accepted start issues an optional wake frame (auto modes) and a
// conversion frame, and reports the conversion frame's data. Holds a
// pending configuration until the next conversion frame.
// Assumes the frame engine drops ready the cycle after go.
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter logic [PM_W-1:0]   INIT_PM   = 2'b00,
    parameter logic [CHAN_W-1:0] INIT_CHAN = '0,
    parameter logic [3:0]        CTRL_LOW  = 4'b0001
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               cfg_load,
    input  cfg_t               cfg_in,
    input  logic               eng_ready,
    input  logic               frame_end,
    input  logic [FRAME_W-1:0] rx_word,
    output logic               frm_go,
    output logic [FRAME_W-1:0] frm_word,
    output logic               busy,
    output logic               res_valid,
    output logic [CHAN_W-1:0]  res_chan,
    output logic [DATA_W-1:0]  res_data
);
    localparam int            INIT_FRAMES = 3;
    localparam int            ICNT_W      = $clog2(INIT_FRAMES);
    localparam logic [ICNT_W-1:0] ICNT_LAST = ICNT_W'(INIT_FRAMES - 1);

    typedef enum logic [1:0] {S_INIT, S_IDLE, S_WAKE, S_CONV} sst_e;

    sst_e               st;
    logic [ICNT_W-1:0]  init_cnt;
    logic               inflight;
    cfg_t               active;
    cfg_t               pending;
    logic               pend_vld;
    logic [FRAME_W-1:0] wr_word;
    logic               write_now;

    adc_ctrl_word #(.CTRL_LOW(CTRL_LOW)) u_word (
        .wr   (1'b1),
        .cfg  (pending),
        .word (wr_word)
    );

    // Launch a frame when a sequence step needs one and the engine is free.
    always_comb begin
        frm_go    = (st != S_IDLE) && !inflight && eng_ready;
        write_now = ((st == S_INIT) && (init_cnt == ICNT_LAST)) ||
                    ((st == S_CONV) && pend_vld);
        busy      = (st != S_IDLE);
    end

    // Choose the command word for the frame about to launch.
    always_comb begin
        if (write_now) begin
            frm_word = wr_word;
        end else if (st == S_INIT) begin
            frm_word = '1;
        end else begin
            frm_word = '0;
        end
    end

    // Sequence state, configuration bookkeeping and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_INIT;
            init_cnt  <= '0;
            inflight  <= 1'b0;
            active    <= '{pm: INIT_PM, chan: INIT_CHAN};
            pending   <= '{pm: INIT_PM, chan: INIT_CHAN};
            pend_vld  <= 1'b0;
            res_valid <= 1'b0;
            res_chan  <= '0;
            res_data  <= '0;
        end else begin
            res_valid <= 1'b0;
            if (frm_go) begin
                inflight <= 1'b1;
                if (write_now) begin
                    active   <= pending;
                    pend_vld <= 1'b0;
                end
            end
            if (frame_end && inflight) begin
                inflight <= 1'b0;
                case (st)
                    S_INIT: begin
                        init_cnt <= init_cnt + 1'b1;
                        if (init_cnt == ICNT_LAST) begin
                            st <= S_IDLE;
                        end
                    end
                    S_WAKE: st <= S_CONV;
                    S_CONV: begin
                        st        <= S_IDLE;
                        res_valid <= 1'b1;
                        res_chan  <= rx_word[FRAME_W-1 -: CHAN_W];
                        res_data  <= rx_word[DATA_W-1:0];
                    end
                    default: st <= S_IDLE;
                endcase
            end
            if ((st == S_IDLE) && start) begin
                st <= pm_is_auto(active.pm) ? S_WAKE : S_CONV;
            end
            if (cfg_load) begin
                pending  <= cfg_in;
                pend_vld <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/adc_pwr_seq_ctrl.sv
// Module: top of the serial converter controller. Joins the sequencer
// and the frame engine. Assumes the converter shifts its return bits
// out on falling serial clock edges, starting at the chip-select fall.
module adc_pwr_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int          SCLK_HALF = 2,
    parameter int          QUIET_CYC = 3,
    parameter logic [1:0]  INIT_PM   = 2'b00,
    parameter logic [3:0]  INIT_CHAN = 4'd0,
    parameter logic [3:0]  CTRL_LOW  = 4'b0001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_load,
    input  logic [1:0]  cfg_pm,
    input  logic [3:0]  cfg_chan,
    input  logic        start,
    output logic        busy,
    output logic        res_valid,
    output logic [3:0]  res_chan,
    output logic [11:0] res_data,
    output logic        adc_cs_n,
    output logic        adc_sclk,
    output logic        adc_din,
    input  logic        adc_dout
);
    logic               eng_ready;
    logic               frame_end;
    logic               frm_go;
    logic [FRAME_W-1:0] frm_word;
    logic [FRAME_W-1:0] rx_word;
    cfg_t               cfg_in;

    assign cfg_in = '{pm: cfg_pm, chan: cfg_chan};

    adc_seq_fsm #(
        .INIT_PM   (INIT_PM),
        .INIT_CHAN (INIT_CHAN),
        .CTRL_LOW  (CTRL_LOW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cfg_load  (cfg_load),
        .cfg_in    (cfg_in),
        .eng_ready (eng_ready),
        .frame_end (frame_end),
        .rx_word   (rx_word),
        .frm_go    (frm_go),
        .frm_word  (frm_word),
        .busy      (busy),
        .res_valid (res_valid),
        .res_chan  (res_chan),
        .res_data  (res_data)
    );

    adc_frame_xfer #(
        .HALF    (SCLK_HALF),
        .QUIET   (QUIET_CYC),
        .FRAME_W (FRAME_W)
    ) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (frm_go),
        .word      (frm_word),
        .ready     (eng_ready),
        .frame_end (frame_end),
        .rx_word   (rx_word),
        .cs_n      (adc_cs_n),
        .sclk      (adc_sclk),
        .din       (adc_din),
        .dout      (adc_dout)
    );

endmodule

// File: rtl/adc_pwr_seq_ctrl_chk.sv
// Module: protocol checker bound to the controller top. Observes the
// link pins and the result strobe only.
module adc_pwr_seq_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic adc_cs_n,
    input logic adc_sclk,
    input logic adc_din,
    input logic busy,
    input logic res_valid
);
    // R2: serial clock parked high outside frames.
    a_r2_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> adc_sclk);

    // R4: command line steady through a high serial clock phase.
    a_r4_din_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_cs_n && adc_sclk && $past(!adc_cs_n && adc_sclk)) |-> $stable(adc_din));

    // R7: strobe one clock after the chip-select rise.
    a_r7_valid_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($past(adc_cs_n) && !$past(adc_cs_n, 2)));

    // R7: strobe lasts one clock.
    a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R9: no frame on the link while idle.
    a_r9_idle_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> adc_cs_n);

endmodule

bind adc_pwr_seq_ctrl adc_pwr_seq_ctrl_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .adc_cs_n  (adc_cs_n),
    .adc_sclk  (adc_sclk),
    .adc_din   (adc_din),
    .busy      (busy),
    .res_valid (res_valid)
);

// File: tb/adc_pwr_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_pwr_seq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [1:0]  cfg_pm = 2'b00;
    logic [3:0]  cfg_chan = 4'd0;
    logic        start = 1'b0;
    logic        busy;
    logic        res_valid;
    logic [3:0]  res_chan;
    logic [11:0] res_data;
    logic        adc_cs_n;
    logic        adc_sclk;
    logic        adc_din;
    logic        dout_r = 1'b0;

    always #2 clk = ~clk;

    adc_pwr_seq_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_load  (cfg_load),
        .cfg_pm    (cfg_pm),
        .cfg_chan  (cfg_chan),
        .start     (start),
        .busy      (busy),
        .res_valid (res_valid),
        .res_chan  (res_chan),
        .res_data  (res_data),
        .adc_cs_n  (adc_cs_n),
        .adc_sclk  (adc_sclk),
        .adc_din   (adc_din),
        .adc_dout  (dout_r)
    );

    int total = 0;
    int bad = 0;
    logic [15:0] exp_q[$];
    int frame_idx = 0;
    logic [15:0] din_log[0:63];
    int rc_log[0:63];
    logic [15:0] din_acc = '0;
    int rc = 0;
    logic [15:0] mw = '0;
    int nsh = 0;
    logic cs_h1 = 1'b1;
    logic cs_h2 = 1'b1;

    function automatic logic [15:0] mword(input int i);
        logic [3:0]  c;
        logic [11:0] d;
        c = 4'(i * 7 + 3);
        d = 12'(i * 419 + 77);
        return {c, d};
    endfunction

    function automatic logic [15:0] ctrl(input logic [3:0] ch, input logic [1:0] pm);
        return {1'b1, 1'b0, ch, pm, 4'b0001, 4'b0000};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Converter model: return word per frame, MSB at CS fall, shift on SCLK fall.
    always @(negedge adc_cs_n or negedge adc_sclk) begin
        if (rst_n) begin
            if (adc_sclk) begin
                mw     = mword(frame_idx);
                dout_r = mw[15];
                nsh    = 0;
            end else if (!adc_cs_n) begin
                if (nsh > 0 && nsh < 16) dout_r = mw[15 - nsh];
                nsh++;
            end
        end
    end

    // Command capture on SCLK rise and frame logging on CS rise.
    always @(posedge adc_sclk or posedge adc_cs_n) begin
        if (rst_n) begin
            if (adc_cs_n) begin
                if (rc > 0) begin
                    if (frame_idx < 64) begin
                        din_log[frame_idx] = din_acc;
                        rc_log[frame_idx]  = rc;
                    end
                    frame_idx++;
                end
                din_acc = '0;
                rc      = 0;
            end else begin
                din_acc = {din_acc[14:0], adc_din};
                rc++;
            end
        end
    end

    // Monitor: pop the expected item on every result strobe.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && res_valid) begin
                chk("R7", "cs rose one clock before strobe", {30'd0, cs_h2, cs_h1}, 32'h1);
                if (exp_q.size() == 0) begin
                    chk("R7", "unexpected result", 32'(res_data), 32'hFFFFFFFF);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk("R7", "res_chan", 32'(res_chan), 32'(e[15:12]));
                    chk("R7", "res_data", 32'(res_data), 32'(e[11:0]));
                end
            end
            cs_h2 = cs_h1;
            cs_h1 = adc_cs_n;
        end
    end

    task automatic wait_idle();
        do @(negedge clk); while (busy);
    endtask

    task automatic load_cfg(input logic [1:0] pm, input logic [3:0] ch);
        @(negedge clk);
        cfg_pm = pm; cfg_chan = ch; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // Driver: one conversion; pushes the expected result and checks frames.
    task automatic do_conv(input bit auto_now, input logic [15:0] exp_din,
                           input bit mid_cfg, input logic [1:0] mpm,
                           input logic [3:0] mch, input bit extra_start);
        int f0;
        int nf;
        f0 = frame_idx;
        nf = auto_now ? 2 : 1;
        exp_q.push_back(mword(f0 + nf - 1));
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (mid_cfg || extra_start) begin
            repeat (10) @(negedge clk);
            if (extra_start) start = 1'b1;
            if (mid_cfg) begin
                cfg_pm = mpm; cfg_chan = mch; cfg_load = 1'b1;
            end
            @(negedge clk);
            start = 1'b0; cfg_load = 1'b0;
        end
        wait_idle();
        repeat (4) @(negedge clk);
        if (auto_now) begin
            chk("R5", "frames per auto conversion", 32'(frame_idx - f0), 32'd2);
            chk("R5", "wake frame command word", 32'(din_log[f0]), 32'h0);
        end else begin
            chk("R6", "frames per single conversion", 32'(frame_idx - f0), 32'd1);
        end
        chk("R8", "conversion frame command word", 32'(din_log[f0 + nf - 1]), 32'(exp_din));
        chk("R2", "sclk rises in frame", 32'(rc_log[f0 + nf - 1]), 32'd16);
        chk("R7", "results outstanding", 32'(exp_q.size()), 32'd0);
        if (extra_start) chk("R9", "busy after ignored start", 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R1", "cs_n in reset", 32'(adc_cs_n), 32'd1);
        chk("R1", "sclk in reset", 32'(adc_sclk), 32'd1);
        chk("R1", "res_valid in reset", 32'(res_valid), 32'd0);
        chk("R1", "busy in reset", 32'(busy), 32'd1);
        rst_n = 1'b1;
        wait_idle();
        repeat (2) @(negedge clk);
        chk("R3", "start-up frame count", 32'(frame_idx), 32'd3);
        chk("R3", "start-up frame 1 command", 32'(din_log[0]), 32'hFFFF);
        chk("R3", "start-up frame 2 command", 32'(din_log[1]), 32'hFFFF);
        chk("R4", "start-up control write", 32'(din_log[2]), 32'(ctrl(4'd0, 2'b00)));
        for (int i = 0; i < 3; i++) chk("R2", "start-up sclk rises", 32'(rc_log[i]), 32'd16);

        // R5: auto standby conversions
        for (int i = 0; i < 3; i++) do_conv(1'b1, 16'h0, 1'b0, 2'b00, 4'd0, 1'b0);
        // R8: load while idle goes out after the wake frame
        load_cfg(2'b11, 4'd5);
        do_conv(1'b1, ctrl(4'd5, 2'b11), 1'b0, 2'b00, 4'd0, 1'b0);
        // R6: normal mode, nothing pending
        do_conv(1'b0, 16'h0, 1'b0, 2'b00, 4'd0, 1'b0);
        do_conv(1'b0, 16'h0, 1'b0, 2'b00, 4'd0, 1'b0);
        // R8: load inside a frame is held for the next one
        do_conv(1'b0, 16'h0, 1'b1, 2'b01, 4'd9, 1'b0);
        // R10: mode switch to auto only counts once written
        do_conv(1'b0, ctrl(4'd9, 2'b01), 1'b0, 2'b00, 4'd0, 1'b0);
        // R9: auto shutdown with a second start mid-conversion
        do_conv(1'b1, 16'h0, 1'b0, 2'b00, 4'd0, 1'b1);
        // R6: full shutdown is not an auto mode
        load_cfg(2'b10, 4'd2);
        do_conv(1'b1, ctrl(4'd2, 2'b10), 1'b0, 2'b00, 4'd0, 1'b0);
        do_conv(1'b0, 16'h0, 1'b0, 2'b00, 4'd0, 1'b1);
        load_cfg(2'b00, 4'd15);
        do_conv(1'b0, ctrl(4'd15, 2'b00), 1'b0, 2'b00, 4'd0, 1'b0);
        do_conv(1'b1, 16'h0, 1'b0, 2'b00, 4'd0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule